// File: doc/BRIEF.md
# Expansion ROM Base Register Controller

This block holds the base address register for an optional expansion ROM and keeps track of whether, and where, that ROM is currently placed in the address map. Configuration software writes a full dword to the register and can read it back. The block decides from each write whether the ROM window must be placed, removed or moved. It then tells a downstream address decoder by single-cycle request pulses, each carrying the address it refers to.

The ROM size is fixed at build time by a mask parameter. The mask holds ones in the address bits the register implements and zero in bit 0. A mask of zero means no ROM is fitted. The block reports the mask's two's complement as the window size. It can tell a size probe apart from a real programming write, and it never moves a live window in one step: the old window is removed first and the new one is placed one cycle later.

Top module: `rom_bar_ctrl`

## Requirements
- R1: After reset the register reads zero, `mapped` is low, `map_base` is zero and neither request pulse is high.
- R2: `rom_size` equals the bitwise inverse of the mask plus one, modulo 2^AW.
- R3: A write that the block accepts stores `wr_data & (mask | 1)`. Bit 0 of the stored value is the enable bit and the bits set in the mask hold the ROM address. `rd_data` shows the stored value from the cycle after the write.
- R4: A write whose data has every mask bit set is a size probe. It is stored as in R3 but raises no pulse and leaves `mapped` and `map_base` unchanged.
- R5: An accepted non-probe write with bit 0 set and a nonzero address field, made while nothing is mapped, raises `map_pulse` in the next cycle with `req_addr` equal to that address. From then on `mapped` is high and `map_base` equals that address.
- R6: Enabling again at the address already mapped raises no pulse.
- R7: Enabling at a different nonzero address while mapped raises `unmap_pulse` with the old address in the next cycle, then `map_pulse` with the new address in the cycle after that. `mapped` is low in the cycle between them.
- R8: An accepted non-probe write with bit 0 clear, made while mapped, raises `unmap_pulse` with the old address. `mapped` then goes low and `map_base` goes to zero.
- R9: An accepted non-probe write with bit 0 set and an address field of zero removes any current mapping as in R8 and maps nothing.
- R10: A removal request made while nothing is mapped raises no pulse.
- R11: With a zero mask every write is ignored: `rd_data` stays zero and no pulse is ever raised.
- R12: A write that lands in the cycle in which a relocation's map pulse is due cancels that map. The write is then judged as if nothing were mapped.
- R13: `map_pulse` and `unmap_pulse` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Dword write strobe for the register |
| wr_data | input | AW | Write data |
| rd_data | output | AW | Stored register value |
| mapped | output | 1 | A ROM window is currently placed |
| map_base | output | AW | Base of the placed window, zero when none |
| rom_size | output | AW | Window size derived from the mask |
| map_pulse | output | 1 | One-cycle request to place a window at `req_addr` |
| unmap_pulse | output | 1 | One-cycle request to remove the window at `req_addr` |
| req_addr | output | AW | Address belonging to the current pulse |

## Verification
Two actions can meet in one cycle: the deferred second half of a relocation and a fresh register write. The bench provokes this by writing a new enabled address in the cycle directly after a relocating write. It expects the pending map to be dropped and the new write to be judged against an empty mapping, so a single map pulse appears carrying only the newest address. Random write sequences with frequent back-to-back writes create the same collision many more times. Every cycle is compared against a reference model built from the requirements.

// File: rtl/rom_bar_pkg.sv
package rom_bar_pkg;
   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_MAP   = 2'd1,
      ACT_UNMAP = 2'd2,
      ACT_MOVE  = 2'd3
   } rom_act_e;
endpackage

// File: rtl/rom_bar_classify.sv
module rom_bar_classify
   import rom_bar_pkg::*;
#(
   parameter int          AW       = 32,
   parameter logic [AW-1:0] ROM_MASK = '0
) (
   input  logic [AW-1:0] wr_data,
   input  logic [AW-1:0] cur_base,
   output logic [AW-1:0] store_val,
   output logic [AW-1:0] new_addr,
   output logic          is_probe,
   output rom_act_e      act
);
   localparam logic [AW-1:0] KEEP_BITS = ROM_MASK | {{(AW-1){1'b0}}, 1'b1};

   logic enable_bit;

   assign store_val  = wr_data & KEEP_BITS;
   assign new_addr   = store_val & ROM_MASK;
   assign enable_bit = store_val[0];
   assign is_probe   = ((wr_data & ROM_MASK) == ROM_MASK);

   always_comb begin
      act = ACT_NONE;
      if (!is_probe) begin
         if (enable_bit && (new_addr != '0)) begin
            if (new_addr == cur_base)   act = ACT_NONE;
            else if (cur_base != '0)    act = ACT_MOVE;
            else                        act = ACT_MAP;
         end else if (cur_base != '0) begin
            act = ACT_UNMAP;
         end
      end
   end
endmodule

// File: rtl/rom_bar_sequencer.sv
module rom_bar_sequencer
   import rom_bar_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_ok,
   input  rom_act_e      act,
   input  logic [AW-1:0] new_addr,
   output logic          mapped,
   output logic [AW-1:0] map_base,
   output logic          map_pulse,
   output logic          unmap_pulse,
   output logic [AW-1:0] req_addr
);
   logic          pend_q;
   logic [AW-1:0] pend_addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_addr_q <= '0;
         map_base    <= '0;
         map_pulse   <= 1'b0;
         unmap_pulse <= 1'b0;
         req_addr    <= '0;
      end else begin
         map_pulse   <= 1'b0;
         unmap_pulse <= 1'b0;
         if (wr_ok) begin
            pend_q <= 1'b0;
            unique case (act)
               ACT_MAP: begin
                  map_pulse <= 1'b1;
                  req_addr  <= new_addr;
                  map_base  <= new_addr;
               end
               ACT_UNMAP: begin
                  unmap_pulse <= 1'b1;
                  req_addr    <= map_base;
                  map_base    <= '0;
               end
               ACT_MOVE: begin
                  unmap_pulse <= 1'b1;
                  req_addr    <= map_base;
                  map_base    <= '0;
                  pend_q      <= 1'b1;
                  pend_addr_q <= new_addr;
               end
               default: ;
            endcase
         end else if (pend_q) begin
            map_pulse <= 1'b1;
            req_addr  <= pend_addr_q;
            map_base  <= pend_addr_q;
            pend_q    <= 1'b0;
         end
      end
   end

   assign mapped = (map_base != '0);

   assert_pulse_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !(map_pulse && unmap_pulse));

   assert_unmap_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      unmap_pulse |-> (!mapped && map_base == '0));

   assert_map_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      map_pulse |-> (mapped && map_base == req_addr));

   assert_move_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (unmap_pulse && pend_q && !wr_ok) |=> (map_pulse && req_addr == $past(pend_addr_q)));

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_ok && !pend_q) |=> (!map_pulse && !unmap_pulse));

   assert_cancel_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && wr_ok && act == ACT_NONE) |=> !map_pulse);
endmodule

// File: rtl/rom_bar_ctrl.sv
module rom_bar_ctrl
   import rom_bar_pkg::*;
#(
   parameter int            AW       = 32,
   parameter logic [AW-1:0] ROM_MASK = 32'hFFFF_0000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_data,
   output logic [AW-1:0] rd_data,
   output logic          mapped,
   output logic [AW-1:0] map_base,
   output logic [AW-1:0] rom_size,
   output logic          map_pulse,
   output logic          unmap_pulse,
   output logic [AW-1:0] req_addr
);
   localparam logic [AW-1:0] WIN_SIZE = ~ROM_MASK + {{(AW-1){1'b0}}, 1'b1};
   localparam bit            HAS_ROM  = (ROM_MASK != '0);

   generate
      if (AW < 12) begin : g_bad_width
         $error("rom_bar_ctrl: AW must be at least 12");
      end
      if (ROM_MASK[0] != 1'b0) begin : g_bad_mask_lsb
         $error("rom_bar_ctrl: mask bit 0 is the enable bit and must be zero");
      end
      if (HAS_ROM && ((WIN_SIZE & (WIN_SIZE - 1'b1)) != '0)) begin : g_bad_mask_shape
         $error("rom_bar_ctrl: mask must be a contiguous run of ones from the top");
      end
   endgenerate

   logic [AW-1:0] bar_q;
   logic [AW-1:0] store_val;
   logic [AW-1:0] new_addr;
   logic          is_probe;
   logic          wr_ok;
   rom_act_e      act;

   assign wr_ok = wr_en && HAS_ROM;

   rom_bar_classify #(.AW(AW), .ROM_MASK(ROM_MASK)) u_classify (
      .wr_data  (wr_data),
      .cur_base (map_base),
      .store_val(store_val),
      .new_addr (new_addr),
      .is_probe (is_probe),
      .act      (act)
   );

   rom_bar_sequencer #(.AW(AW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_ok      (wr_ok),
      .act        (act),
      .new_addr   (new_addr),
      .mapped     (mapped),
      .map_base   (map_base),
      .map_pulse  (map_pulse),
      .unmap_pulse(unmap_pulse),
      .req_addr   (req_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      bar_q <= '0;
      else if (wr_ok)  bar_q <= store_val;
   end

   assign rd_data  = bar_q;
   assign rom_size = WIN_SIZE;

   assert_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |=> rd_data == $past(wr_data & (ROM_MASK | {{(AW-1){1'b0}}, 1'b1})));

   assert_probe_still_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && is_probe && !map_pulse && !unmap_pulse && !u_seq.pend_q)
         |=> (!map_pulse && !unmap_pulse && $stable(map_base)));

   assert_nowrite_norom_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !HAS_ROM |-> (rd_data == '0 && !map_pulse && !unmap_pulse));
endmodule

// File: tb/tb_rom_bar_ctrl.sv
module tb_rom_bar_ctrl;
   localparam int          CLK_PERIOD = 10;
   localparam int          AW         = 32;
   localparam logic [31:0] MASK       = 32'hFFFF_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;

   logic [31:0] rd_data, map_base, rom_size, req_addr;
   logic        mapped, map_pulse, unmap_pulse;
   logic [31:0] n_rd_data, n_map_base, n_rom_size, n_req_addr;
   logic        n_mapped, n_map_pulse, n_unmap_pulse;

   always #(CLK_PERIOD/2) clk = ~clk;

   rom_bar_ctrl #(.AW(AW), .ROM_MASK(MASK)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .mapped(mapped), .map_base(map_base), .rom_size(rom_size),
      .map_pulse(map_pulse), .unmap_pulse(unmap_pulse), .req_addr(req_addr));

   rom_bar_ctrl #(.AW(AW), .ROM_MASK(32'h0)) dut_norom (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(n_rd_data), .mapped(n_mapped), .map_base(n_map_base), .rom_size(n_rom_size),
      .map_pulse(n_map_pulse), .unmap_pulse(n_unmap_pulse), .req_addr(n_req_addr));

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [31:0] m_reg, m_base, m_pend_addr;
   bit          m_pend;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] actual, input logic [31:0] expected);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, actual, expected);
      end
   endtask

   function automatic logic [31:0] keep(input logic [31:0] d);
      return d & (MASK | 32'h1);
   endfunction

   task automatic cycle(input bit we, input logic [31:0] d, input string tag);
      bit e_map, e_unmap;
      logic [31:0] e_addr, a, nv;
      e_map = 0; e_unmap = 0; e_addr = '0;
      wr_en = we; wr_data = d;
      if (we) begin
         m_pend = 0;
         nv = keep(d);
         m_reg = nv;
         if ((d & MASK) != MASK) begin
            a = nv & MASK;
            if (nv[0] && a != 0) begin
               if (a != m_base) begin
                  if (m_base != 0) begin
                     e_unmap = 1; e_addr = m_base; m_base = 0;
                     m_pend = 1; m_pend_addr = a;
                  end else begin
                     e_map = 1; e_addr = a; m_base = a;
                  end
               end
            end else if (m_base != 0) begin
               e_unmap = 1; e_addr = m_base; m_base = 0;
            end
         end
      end else if (m_pend) begin
         e_map = 1; e_addr = m_pend_addr; m_base = m_pend_addr; m_pend = 0;
      end
      @(negedge clk);
      wr_en = 1'b0;
      chk(rd_data == m_reg, tag, "rd_data", rd_data, m_reg);
      chk(map_base == m_base, tag, "map_base", map_base, m_base);
      chk(mapped == (m_base != 0), tag, "mapped", {31'b0, mapped}, {31'b0, m_base != 0});
      chk(map_pulse == e_map, tag, "map_pulse", {31'b0, map_pulse}, {31'b0, e_map});
      chk(unmap_pulse == e_unmap, tag, "unmap_pulse", {31'b0, unmap_pulse}, {31'b0, e_unmap});
      if (e_map || e_unmap) chk(req_addr == e_addr, tag, "req_addr", req_addr, e_addr);
      chk(n_rd_data == 0 && !n_map_pulse && !n_unmap_pulse && !n_mapped, "R11",
          "norom_state", n_rd_data, 32'h0);
   endtask

   function automatic logic [31:0] pick_addr(input int unsigned r);
      case (r % 4)
         0: return 32'h0012_0000;
         1: return 32'h0034_0000;
         2: return 32'hABCD_0000;
         default: return 32'h0000_0000;
      endcase
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      m_reg = 0; m_base = 0; m_pend = 0; m_pend_addr = 0;
      void'($urandom(32'd12345));
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(rd_data == 0, "R1", "rd_data", rd_data, 0);
      chk(!mapped && map_base == 0, "R1", "map_base", map_base, 0);
      chk(!map_pulse && !unmap_pulse, "R1", "pulses", {30'b0, map_pulse, unmap_pulse}, 0);
      // R2 size
      chk(rom_size == 32'h0001_0000, "R2", "rom_size", rom_size, 32'h0001_0000);
      chk(n_rom_size == 32'h0, "R2", "norom_size", n_rom_size, 32'h0);

      cycle(1, 32'hFFFF_FFFF, "R4");          // probe: stores FFFF0001, no map
      cycle(1, 32'h0000_0000, "R10");         // disable with nothing mapped
      cycle(1, 32'h0012_0001, "R5");          // first map
      cycle(1, 32'h0012_0001, "R6");          // same address, quiet
      cycle(1, 32'hFFFF_0000, "R4");          // probe while mapped keeps mapping
      cycle(1, 32'h0034_0001, "R7");          // relocation: unmap now
      cycle(0, 32'h0, "R7");                  // then map
      cycle(1, 32'h0000_0001, "R9");          // enabled with zero address field
      cycle(1, 32'h00AB_1235, "R3");          // low bits dropped, maps 00AB0000
      cycle(1, 32'h00AB_0000, "R8");          // disable while mapped
      cycle(1, 32'h0070_0001, "R5");
      cycle(1, 32'h0080_0001, "R12");         // relocation starts
      cycle(1, 32'h0090_0001, "R12");         // lands on pending map slot
      cycle(0, 32'h0, "R12");
      cycle(0, 32'h0, "R12");

      for (int i = 0; i < 400; i++) begin
         int unsigned r;
         logic [31:0] d;
         r = $urandom;
         if (r[3:0] == 0)      d = 32'hFFFF_0000 | {31'b0, r[4]};
         else                  d = pick_addr(r >> 5) | {16'b0, r[23:8]} & 32'h0000_FFFE
                                   | {31'b0, r[6] | r[7]};
         cycle(r[30] | r[29], d, "R3");
      end
      cycle(0, 32'h0, "R7");
      cycle(0, 32'h0, "R10");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule